// File: doc/BRIEF.md
# Four-Lane Receive Deskew Aligner

This block takes four receive lanes that each deliver one decoded code group per clock (an 8-bit value plus a control flag) together with a per-lane sync indication, and removes the skew between them. The transmitter places an alignment marker on all four lanes in the same column during the gap between packets. Lane skew makes those markers arrive at different times. Each lane owns a small FIFO. A lane's FIFO stays empty until that lane sees its first marker. From then on the FIFO stores every group the lane delivers, while nothing is read from any FIFO.

When the last lane's marker arrives soon enough after the first, all four FIFOs start reading in the same cycle. The output then presents the four lanes column-aligned, starting with the marker column. If the markers are spread too widely, the block discards what it has stored and waits for the next marker column. Losing sync on any lane drops alignment and empties the FIFOs. While the block is not aligned, every output lane carries an idle control group and the output valid flag is low.

Top module: `lane_skew_aligner`

## Requirements
- R1: After reset, `alignedOut` and `outValid` are low and every output lane shows the idle group (value 0xBC with the control flag set).
- R2: The alignment marker is the value 0x7C with the lane's control flag set. A value of 0x7C with the control flag clear is ordinary data and never starts or completes alignment.
- R3: While any `rxSync` bit is low, markers are ignored and alignment cannot be reached. Once all four bits are high, the next marker column can align the lanes.
- R4: A lane's FIFO stores nothing before its first marker, and that marker is its first entry. In the cycle after alignment is reached, all four output lanes show the marker.
- R5: If the last lane's marker arrives at most WINDOW-1 cycles after the first lane's marker (WINDOW = 10), `alignedOut` rises at the clock edge that samples the last marker. From the next cycle on, each cycle presents the next transmitted column on all four lanes, in transmit order.
- R6: If some lane has not seen its marker by the edge WINDOW-1 cycles after the first marker, every FIFO is emptied and the block waits for a new first marker. A lane skew of WINDOW cycles or more relative to another lane therefore never aligns.
- R7: Once high, `alignedOut` stays high while all `rxSync` bits stay high. The clock edge that samples any `rxSync` bit low clears `alignedOut` and empties all FIFOs, so realignment needs a new marker column.
- R8: `outValid` always equals `alignedOut`. While it is low, each output lane presents value 0xBC with the control flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock shared by all lanes |
| rst | input | 1 | Synchronous active-high reset |
| rxData | input | LANES*8 | Decoded code group values, lane i in bits [8i+7:8i] |
| rxCtl | input | LANES | Control flag of each lane's code group |
| rxSync | input | LANES | Per-lane sync status, high when the lane is synchronized |
| outData | output | LANES*8 | Aligned code group values, same lane packing as the input |
| outCtl | output | LANES | Control flag of each aligned output group |
| outValid | output | 1 | High while the output carries aligned lane data |
| alignedOut | output | 1 | Alignment status |

## Verification
The bench aims at the edge of the window. A skew spread of exactly nine cycles must align, and a spread of ten must not. A design that is off by one in its window counter would either never lock at the nine-cycle limit or lock on a spread that cannot be trusted. Look-alike markers (0x7C with the control flag clear) and markers that arrive while one lane is out of sync must be ignored. A design that tests only the value, or that ignores sync, would lock onto data or onto a lane that is not yet synchronized. After every lock the first column must be the marker on all four lanes, and later columns must follow transmit order. A design whose write pointers start one group early or late would show a shifted lane. Dropping sync while aligned must end alignment at the next edge; a design that fails to clear its pointers would replay stale columns after relock.

// File: rtl/skew_align_pkg.sv
package skew_align_pkg;

  localparam logic [7:0] MARK_CODE = 8'h7C;
  localparam logic [7:0] IDLE_CODE = 8'hBC;

  // strobes from control to the lane FIFOs
  typedef struct packed {
    logic clr;   // empty every FIFO
    logic rdEn;  // advance all read pointers together
    logic show;  // present FIFO heads instead of idle
  } deskew_strobe_t;

endpackage

// File: rtl/skew_align_ctrl.sv
module skew_align_ctrl
  import skew_align_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int WINDOW = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LANES*8-1:0]   rxData,
  input  logic [LANES-1:0]     rxCtl,
  input  logic [LANES-1:0]     rxSync,
  output deskew_strobe_t       strb,
  output logic [LANES-1:0]     wrEn,
  output logic                 locked
);

  localparam int CNT_W = $clog2(WINDOW + 1);

  typedef enum logic {HUNT, LOCKED} state_t;

  state_t             state;
  logic [LANES-1:0]   started;
  logic [LANES-1:0]   isMark;
  logic [LANES-1:0]   hit;
  logic [CNT_W-1:0]   winCnt;
  logic               allSync;
  logic               complete;
  logic               expire;

  for (genvar g = 0; g < LANES; g++) begin : g_mark
    assign isMark[g] = rxCtl[g] && (rxData[g*8 +: 8] == MARK_CODE);
  end

  always_comb begin
    allSync  = &rxSync;
    hit      = started | isMark;
    complete = (state == HUNT) && allSync && (&hit);
    expire   = (state == HUNT) && allSync && (|started) && !complete &&
               (winCnt >= CNT_W'(WINDOW - 1));
    strb.clr  = !allSync || expire;
    strb.rdEn = (state == LOCKED) && allSync;
    strb.show = (state == LOCKED);
    if (state == LOCKED)          wrEn = {LANES{allSync}};
    else if (allSync && !expire)  wrEn = hit;
    else                          wrEn = '0;
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clr) begin
      state   <= HUNT;
      started <= '0;
      winCnt  <= '0;
    end else if (state == HUNT) begin
      if (complete) begin
        state   <= LOCKED;
        started <= '1;
      end else begin
        started <= hit;
        if (|hit) winCnt <= winCnt + 1'b1;
      end
    end
  end

  assign locked = (state == LOCKED);

endmodule

// File: rtl/skew_align_lanes.sv
module skew_align_lanes
  import skew_align_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LANES*8-1:0]   rxData,
  input  logic [LANES-1:0]     rxCtl,
  input  deskew_strobe_t       strb,
  input  logic [LANES-1:0]     wrEn,
  output logic [LANES*8-1:0]   outData,
  output logic [LANES-1:0]     outCtl,
  output logic                 outValid
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [8:0]       mem [DEPTH];
    logic [PTR_W-1:0] wPtr;
    logic [PTR_W-1:0] rPtr;
    logic [8:0]       head;

    always_ff @(posedge clk) begin
      if (wrEn[g]) mem[wPtr] <= {rxCtl[g], rxData[g*8 +: 8]};
    end

    always_ff @(posedge clk) begin
      if (rst || strb.clr) begin
        wPtr <= '0;
        rPtr <= '0;
      end else begin
        if (wrEn[g])   wPtr <= nextPtr(wPtr);
        if (strb.rdEn) rPtr <= nextPtr(rPtr);
      end
    end

    assign head              = mem[rPtr];
    assign outData[g*8 +: 8] = strb.show ? head[7:0] : IDLE_CODE;
    assign outCtl[g]         = strb.show ? head[8]   : 1'b1;
  end

  assign outValid = strb.show;

endmodule

// File: rtl/lane_skew_aligner.sv
module lane_skew_aligner
  import skew_align_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DEPTH  = 16,
  parameter int WINDOW = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LANES*8-1:0] rxData,
  input  logic [LANES-1:0]   rxCtl,
  input  logic [LANES-1:0]   rxSync,
  output logic [LANES*8-1:0] outData,
  output logic [LANES-1:0]   outCtl,
  output logic               outValid,
  output logic               alignedOut
);

  deskew_strobe_t   strb;
  logic [LANES-1:0] wrEn;

  skew_align_ctrl #(.LANES(LANES), .WINDOW(WINDOW)) ctrl_i (
    .clk(clk), .rst(rst), .rxData(rxData), .rxCtl(rxCtl), .rxSync(rxSync),
    .strb(strb), .wrEn(wrEn), .locked(alignedOut)
  );

  skew_align_lanes #(.LANES(LANES), .DEPTH(DEPTH)) lanes_i (
    .clk(clk), .rst(rst), .rxData(rxData), .rxCtl(rxCtl),
    .strb(strb), .wrEn(wrEn),
    .outData(outData), .outCtl(outCtl), .outValid(outValid)
  );

endmodule

// File: rtl/skew_align_chk.sv
module skew_align_chk
  import skew_align_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [LANES-1:0]   rxSync,
  input logic [LANES*8-1:0] outData,
  input logic [LANES-1:0]   outCtl,
  input logic               outValid,
  input logic               alignedOut
);

  // R8
  idle_when_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
    !alignedOut |-> (outCtl == '1 && outData == {LANES{IDLE_CODE}}));

  // R8
  valid_tracks_lock_chk: assert property (@(posedge clk) disable iff (rst)
    outValid == alignedOut);

  // R7
  unlock_on_sync_loss_chk: assert property (@(posedge clk) disable iff (rst)
    !(&rxSync) |=> !alignedOut);

  // R7
  lock_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (alignedOut && (&rxSync)) |=> alignedOut);

  // R4
  marker_column_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alignedOut) |-> (outCtl == '1 && outData == {LANES{MARK_CODE}}));

  // R3
  lock_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alignedOut) |-> $past(&rxSync));

endmodule

bind lane_skew_aligner skew_align_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst(rst), .rxSync(rxSync), .outData(outData), .outCtl(outCtl),
  .outValid(outValid), .alignedOut(alignedOut)
);

// File: tb/lane_skew_aligner_tb_top.sv
module lane_skew_aligner_tb_top;

  localparam int LANES  = 4;
  localparam int DEPTH  = 16;
  localparam int WINDOW = 10;
  localparam int PERIOD = 40;
  localparam logic [8:0] MARK = 9'h17C;
  localparam logic [8:0] IDLE = 9'h1BC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LANES*8-1:0] rxData = '0;
  logic [LANES-1:0]   rxCtl  = '0;
  logic [LANES-1:0]   rxSync = '0;
  logic [LANES*8-1:0] outData;
  logic [LANES-1:0]   outCtl;
  logic               outValid;
  logic               alignedOut;

  always #4 clk = ~clk;

  lane_skew_aligner #(.LANES(LANES), .DEPTH(DEPTH), .WINDOW(WINDOW)) dut_i (
    .clk(clk), .rst(rst), .rxData(rxData), .rxCtl(rxCtl), .rxSync(rxSync),
    .outData(outData), .outCtl(outCtl), .outValid(outValid), .alignedOut(alignedOut)
  );

  int checks = 0;
  int fails  = 0;
  int tcyc   = 0;
  int skew [LANES];
  logic [LANES-1:0] syncCfg = '0;
  bit markersOn = 1'b1;
  bit fakeOn    = 1'b0;
  bit done      = 1'b0;
  bit prevAl    = 1'b0;

  // transmitted column at time t (same on every lane before skew)
  function automatic logic [8:0] txSym(int t);
    if (markersOn && t >= 0 && (t % PERIOD) == 20) return MARK;
    if (fakeOn && (t % 5) == 0) return 9'h07C;
    return {1'b0, 8'((t * 13 + 5) & 255)};
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0d)", tag, what, act, exp, tcyc);
    end
  endtask

  // behavioural reference model
  logic [8:0] mq [LANES][$];
  bit  mAligned = 1'b0;
  bit  mStarted [LANES];
  int  mCnt = 0;

  task automatic modelClear();
    for (int i = 0; i < LANES; i++) begin
      mq[i].delete();
      mStarted[i] = 1'b0;
    end
    mAligned = 1'b0;
    mCnt = 0;
  endtask

  always @(posedge clk) begin
    logic [8:0] sym [LANES];
    bit any, all, newAny;
    for (int i = 0; i < LANES; i++) sym[i] = {rxCtl[i], rxData[i*8 +: 8]};
    if (rst || !(&rxSync)) modelClear();
    else if (mAligned) begin
      for (int i = 0; i < LANES; i++) begin
        mq[i].push_back(sym[i]);
        void'(mq[i].pop_front());
      end
    end else begin
      any = 1'b0; all = 1'b1; newAny = 1'b0;
      for (int i = 0; i < LANES; i++) begin
        any = any | mStarted[i];
        all = all & (mStarted[i] || sym[i] == MARK);
      end
      if (all) begin
        for (int i = 0; i < LANES; i++) begin
          mq[i].push_back(sym[i]);
          mStarted[i] = 1'b1;
        end
        mAligned = 1'b1;
      end else if (any && mCnt >= WINDOW - 1) begin
        modelClear();
      end else begin
        for (int i = 0; i < LANES; i++) begin
          if (mStarted[i] || sym[i] == MARK) begin
            mq[i].push_back(sym[i]);
            mStarted[i] = 1'b1;
            newAny = 1'b1;
          end
        end
        if (newAny) mCnt++;
      end
    end
  end

  task automatic compareAll();
    logic [8:0] exp, act;
    for (int i = 0; i < LANES; i++) begin
      exp = mAligned ? mq[i][0] : IDLE;
      act = {outCtl[i], outData[i*8 +: 8]};
      check(act == exp, mAligned ? "R5" : "R8", $sformatf("lane %0d group", i), int'(act), int'(exp));
    end
    check(alignedOut == mAligned, "R7", "alignedOut vs model", int'(alignedOut), int'(mAligned));
    check(outValid == alignedOut, "R8", "outValid", int'(outValid), int'(alignedOut));
    if (alignedOut && !prevAl) begin
      for (int i = 0; i < LANES; i++) begin
        act = {outCtl[i], outData[i*8 +: 8]};
        check(act == MARK, "R4", $sformatf("first aligned group lane %0d", i), int'(act), int'(MARK));
      end
    end
    prevAl = alignedOut;
  endtask

  task automatic step();
    logic [8:0] s;
    @(negedge clk);
    rxSync = syncCfg;
    for (int i = 0; i < LANES; i++) begin
      s = txSym(tcyc - skew[i]);
      rxCtl[i] = s[8];
      rxData[i*8 +: 8] = s[7:0];
    end
    tcyc++;
    @(posedge clk);
    #2;
    compareAll();
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic setSkew(int a, int b, int c, int d);
    skew[0] = a; skew[1] = b; skew[2] = c; skew[3] = d;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    setSkew(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(alignedOut == 1'b0, "R1", "alignedOut in reset", int'(alignedOut), 0);
    check(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    check(outData == {LANES{8'hBC}} && outCtl == '1, "R1", "idle lanes in reset",
          int'(outData[7:0]), 'hBC);
    rst = 1'b0;

    // R5: no skew
    syncCfg = '1;
    run(60);
    check(alignedOut == 1'b1, "R5", "lock with zero skew", int'(alignedOut), 1);

    // R7: sync loss drops lock at the next edge
    syncCfg[1] = 1'b0;
    step();
    check(alignedOut == 1'b0, "R7", "lock after sync loss", int'(alignedOut), 0);
    check({outCtl[0], outData[7:0]} == IDLE, "R8", "idle after sync loss",
          int'({outCtl[0], outData[7:0]}), int'(IDLE));

    // R5: spread of WINDOW-1 cycles aligns
    setSkew(0, 3, 7, 9);
    run(3);
    syncCfg = '1;
    run(80);
    check(alignedOut == 1'b1, "R5", "lock at window limit", int'(alignedOut), 1);

    // R6: spread of WINDOW cycles never aligns
    syncCfg = '0;
    step();
    setSkew(0, 2, 10, 4);
    syncCfg = '1;
    run(130);
    check(alignedOut == 1'b0, "R6", "no lock beyond window", int'(alignedOut), 0);

    // R2: look-alike markers without control flag
    syncCfg = '0;
    step();
    setSkew(1, 1, 1, 1);
    markersOn = 1'b0;
    fakeOn = 1'b1;
    syncCfg = '1;
    run(90);
    check(alignedOut == 1'b0, "R2", "no lock on data 0x7C", int'(alignedOut), 0);
    markersOn = 1'b1;
    run(60);
    check(alignedOut == 1'b1, "R2", "lock on real markers", int'(alignedOut), 1);
    fakeOn = 1'b0;

    // R3: markers ignored while a lane lacks sync
    syncCfg = 4'b0111;
    run(90);
    check(alignedOut == 1'b0, "R3", "no lock with a lane unsynced", int'(alignedOut), 0);
    syncCfg = '1;
    run(50);
    check(alignedOut == 1'b1, "R3", "lock after full sync", int'(alignedOut), 1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (R5): actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule